// File: doc/BRIEF.md
# DMA Transfer Sequencer with Multiplexed High Address

This block steps through the bus states of a single active DMA service. It also produces the 16-bit memory address for each transfer. The low address byte leaves the block on its own output. The high byte is placed on the 8-bit data bus during an S1 state, and an external latch captures it on the falling edge of the address strobe. The address-enable output lets that latched byte onto the system address bus.

A service starts with a one-cycle `start` pulse. That pulse supplies the first address, the direction (up or down), the transfer count and the timing choice (normal or compressed). Normal timing runs S2, S3 and S4 for each transfer; S3 exists only to widen the read pulse. Compressed timing drops S3, so a transfer takes two clocks. An S1 state is inserted before the first transfer. After that, S1 appears only when stepping the address carries or borrows into the high byte. A long sequential service therefore reloads the latch once in 256 transfers.

Arbitration, the bus handshake and the programmable register file sit outside this block.

Top module: `dma_xfer_sequencer`

## Requirements
- R1: While `rstN` is low, and in the cycle after it goes low, `phase` is 0 (idle) and `addrEn`, `adStrobe`, `rdStrobe`, `wrStrobe` and `tc` are all low.
- R2: The first transfer of every service starts with an S1 state (`phase` = 1). In S1, `adStrobe` is high and `dataOut` carries bits 15..8 of the current address; `dataOut` is 0 in every other state.
- R3: With `compressed` = 0, a transfer follows `phase` 2 (S2), then 3 (S3), then 4 (S4). With `compressed` = 1, S3 is left out and S2 goes directly to S4.
- R4: With normal timing, `rdStrobe` is high in S2, S3 and S4. With compressed timing, `rdStrobe` is high only in S4. `wrStrobe` is high only in S4.
- R5: A service carries out `xferCount` + 1 transfers. `tc` is high only during the S4 of the last transfer.
- R6: While the block is active, `addrLo` shows bits 7..0 of the current address. After each transfer the address steps by one, upward when `countDown` = 0 and downward when `countDown` = 1, and it wraps at the 16-bit limit.
- R7: After the first transfer, S1 is inserted only when bits 15..8 of the next address differ from those of the current address.
- R8: `addrEn` is high from the first S1 through the final S4 and is low in the cycle after the final S4.
- R9: A `start` pulse that arrives while a service is in progress is ignored. The running service continues with its own address, count and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a service when the block is idle |
| startAddr | input | 16 | Address of the first transfer |
| countDown | input | 1 | 1 steps the address downward, 0 upward |
| xferCount | input | 16 | Number of transfers minus one |
| compressed | input | 1 | 1 selects two-clock transfers with no S3 |
| phase | output | 3 | Current state: 0 idle, 1 S1, 2 S2, 3 S3, 4 S4 |
| addrLo | output | 8 | Low address byte, driven directly |
| dataOut | output | 8 | High address byte during S1, otherwise 0 |
| adStrobe | output | 1 | Latch strobe; its falling edge loads the external latch |
| addrEn | output | 1 | Enables the latched high byte onto the address bus |
| rdStrobe | output | 1 | Read pulse |
| wrStrobe | output | 1 | Write pulse |
| tc | output | 1 | Terminal count, high in the S4 of the last transfer |

## Verification
The bench builds the block with its default parameters: a 16-bit address split into an 8-bit low byte and an 8-bit high byte, and a 16-bit count. With these values the bench can reach a carry into the high byte while counting up, a borrow while counting down, and a wrap from FFFF to 0000 and back. A service of 301 transfers crosses exactly one 256-address boundary, which shows that a re-latch happens only at that crossing. A `start` pulse injected during a service and a reset taken mid-service complete the directed cases.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_S1   = 3'd1,
    PH_S2   = 3'd2,
    PH_S3   = 3'd3,
    PH_S4   = 3'd4
  } seqPhase_e;

  // strobes from the control FSM to the address/count datapath
  typedef struct packed {
    logic load;     // capture a new service
    logic step;     // advance address and count at end of S4
    logic driveHi;  // present high byte on the data bus
    logic active;   // a service is running
  } seqCtl_t;

endpackage

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              countDown,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic              compressed,
  output logic [LO_W-1:0]   addrLo,
  output logic [ADDR_W-LO_W-1:0] dataOut,
  output logic [ADDR_W-LO_W-1:0] curHi,
  output logic              hiChange,
  output logic              lastXfer,
  output logic              dirQ,
  output logic              compQ
);

  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [CNT_W-1:0]  remCnt;

  assign nextAddr = dirQ ? (curAddr - ADDR_W'(1)) : (curAddr + ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remCnt  <= '0;
      dirQ    <= 1'b0;
      compQ   <= 1'b0;
    end else if (ctl.load) begin
      curAddr <= startAddr;
      remCnt  <= xferCount;
      dirQ    <= countDown;
      compQ   <= compressed;
    end else if (ctl.step) begin
      curAddr <= nextAddr;
      remCnt  <= remCnt - CNT_W'(1);
    end
  end

  assign curHi    = curAddr[ADDR_W-1:LO_W];
  assign hiChange = (nextAddr[ADDR_W-1:LO_W] != curAddr[ADDR_W-1:LO_W]);
  assign lastXfer = (remCnt == '0);

  assign addrLo  = ctl.active  ? curAddr[LO_W-1:0] : '0;
  assign dataOut = ctl.driveHi ? curAddr[ADDR_W-1:LO_W] : HI_W'(0);

endmodule

// File: rtl/dma_seq_control.sv
module dma_seq_control
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      hiChange,
  input  logic      lastXfer,
  input  logic      compQ,
  output seqCtl_t   ctl,
  output seqPhase_e phase,
  output logic      adStrobe,
  output logic      addrEn,
  output logic      rdStrobe,
  output logic      wrStrobe,
  output logic      tc
);

  seqPhase_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_IDLE: if (start) stateNext = PH_S1;
      PH_S1:   stateNext = PH_S2;
      PH_S2:   stateNext = compQ ? PH_S4 : PH_S3;
      PH_S3:   stateNext = PH_S4;
      PH_S4: begin
        if (lastXfer)      stateNext = PH_IDLE;
        else if (hiChange) stateNext = PH_S1;
        else               stateNext = PH_S2;
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.load    = (state == PH_IDLE) && start;
    ctl.step    = (state == PH_S4);
    ctl.driveHi = (state == PH_S1);
    ctl.active  = (state != PH_IDLE);
  end

  assign phase    = state;
  assign adStrobe = (state == PH_S1);
  assign addrEn   = (state != PH_IDLE);
  assign wrStrobe = (state == PH_S4);
  assign rdStrobe = (state == PH_S4) ||
                    (!compQ && ((state == PH_S2) || (state == PH_S3)));
  assign tc       = (state == PH_S4) && lastXfer;

endmodule

// File: rtl/dma_xfer_sequencer.sv
module dma_xfer_sequencer
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      startAddr,
  input  logic                   countDown,
  input  logic [CNT_W-1:0]       xferCount,
  input  logic                   compressed,
  output logic [2:0]             phase,
  output logic [LO_W-1:0]        addrLo,
  output logic [ADDR_W-LO_W-1:0] dataOut,
  output logic                   adStrobe,
  output logic                   addrEn,
  output logic                   rdStrobe,
  output logic                   wrStrobe,
  output logic                   tc
);

  localparam int HI_W = ADDR_W - LO_W;

  seqCtl_t   ctl;
  seqPhase_e phaseE;
  logic      hiChange, lastXfer, dirQ, compQ;
  logic [HI_W-1:0] curHi;

  dma_seq_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .hiChange (hiChange),
    .lastXfer (lastXfer),
    .compQ    (compQ),
    .ctl      (ctl),
    .phase    (phaseE),
    .adStrobe (adStrobe),
    .addrEn   (addrEn),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .tc       (tc)
  );

  dma_seq_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LO_W   (LO_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startAddr  (startAddr),
    .countDown  (countDown),
    .xferCount  (xferCount),
    .compressed (compressed),
    .addrLo     (addrLo),
    .dataOut    (dataOut),
    .curHi      (curHi),
    .hiChange   (hiChange),
    .lastXfer   (lastXfer),
    .dirQ       (dirQ),
    .compQ      (compQ)
  );

  assign phase = phaseE;

endmodule

// File: rtl/dma_xfer_sequencer_checker.sv
module dma_xfer_sequencer_checker #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      phase,
  input logic            addrEn,
  input logic            rdStrobe,
  input logic            wrStrobe,
  input logic            tc,
  input logic [LO_W-1:0] addrLo,
  input logic [HI_W-1:0] curHi,
  input logic            dirQ,
  input logic            compQ
);

  a_r2_first_has_s1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEn) |-> phase == 3'd1);

  a_r2_s1_then_s2: assert property (@(posedge clk) disable iff (!rstN)
    phase == 3'd1 |=> phase == 3'd2);

  a_r3_comp_skips_s3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2 && compQ) |=> phase == 3'd4);

  a_r3_normal_has_s3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2 && !compQ) |=> phase == 3'd3);

  a_r4_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrStrobe) && !compQ) |-> $past(rdStrobe));

  a_r5_tc_on_write: assert property (@(posedge clk) disable iff (!rstN)
    tc |-> wrStrobe);

  a_r6_low_steps: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2 && $past(phase) == 3'd4) |->
      addrLo == (dirQ ? $past(addrLo) - LO_W'(1) : $past(addrLo) + LO_W'(1)));

  a_r7_skip_keeps_hi: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2 && $past(phase) == 3'd4) |-> curHi == $past(curHi));

  a_r8_aen_drops: assert property (@(posedge clk) disable iff (!rstN)
    tc |=> !addrEn);

endmodule

bind dma_xfer_sequencer dma_xfer_sequencer_checker #(
  .LO_W (LO_W),
  .HI_W (HI_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .phase    (phase),
  .addrEn   (addrEn),
  .rdStrobe (rdStrobe),
  .wrStrobe (wrStrobe),
  .tc       (tc),
  .addrLo   (addrLo),
  .curHi    (curHi),
  .dirQ     (dirQ),
  .compQ    (compQ)
);

// File: tb/dma_xfer_sequencer_test.sv
`timescale 1ns/1ps
module dma_xfer_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] startAddr = '0;
  logic        countDown = 1'b0;
  logic [15:0] xferCount = '0;
  logic        compressed = 1'b0;
  logic [2:0]  phase;
  logic [7:0]  addrLo, dataOut;
  logic        adStrobe, addrEn, rdStrobe, wrStrobe, tc;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_xfer_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .countDown(countDown), .xferCount(xferCount), .compressed(compressed),
    .phase(phase), .addrLo(addrLo), .dataOut(dataOut), .adStrobe(adStrobe),
    .addrEn(addrEn), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .tc(tc)
  );

  // {addr, count, dir, comp, expected S1 count, poke}
  localparam logic [63:0] VEC [8] = '{
    {16'h1234, 16'd3,   8'd0, 8'd0, 8'd1, 8'd0},
    {16'h12FE, 16'd3,   8'd0, 8'd0, 8'd2, 8'd0},
    {16'h1301, 16'd3,   8'd1, 8'd1, 8'd2, 8'd0},
    {16'h00FF, 16'd0,   8'd0, 8'd1, 8'd1, 8'd0},
    {16'hFFFE, 16'd3,   8'd0, 8'd0, 8'd2, 8'd0},
    {16'h0000, 16'd1,   8'd1, 8'd1, 8'd2, 8'd0},
    {16'h4000, 16'd300, 8'd0, 8'd1, 8'd2, 8'd0},
    {16'h1234, 16'd5,   8'd1, 8'd0, 8'd1, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  int cyc;
  bit pokeOn;

  // compare outputs against the expected state, then advance one clock
  task automatic expectCycle(input logic [2:0] ph, input logic rd, input logic wr,
                             input logic [15:0] addr, input logic last);
    check("R3 phase", phase, ph);
    check("R4 rdStrobe", rdStrobe, rd);
    check("R4 wrStrobe", wrStrobe, wr);
    check("R2 adStrobe", adStrobe, ph == 3'd1);
    check("R2 dataOut", dataOut, (ph == 3'd1) ? addr[15:8] : 8'h00);
    check("R8 addrEn", addrEn, 1'b1);
    check("R6 addrLo", addrLo, addr[7:0]);
    check("R5 tc", tc, last);
    cyc++;
    if (pokeOn && cyc == 3) begin
      // R9: a new request mid-service must be ignored
      start = 1'b1; startAddr = 16'hABCD; countDown = ~countDown;
      compressed = ~compressed; xferCount = 16'd99;
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic runService(input logic [15:0] a0, input logic [15:0] cnt,
                            input logic dir, input logic comp,
                            input int expS1, input bit poke);
    logic [15:0] addr, prev;
    int s1Seen;
    addr = a0; prev = a0; s1Seen = 0; cyc = 0; pokeOn = poke;
    startAddr = a0; xferCount = cnt; countDown = dir; compressed = comp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= int'(cnt); t++) begin
      if (t == 0 || addr[15:8] != prev[15:8]) begin
        s1Seen++;
        expectCycle(3'd1, 1'b0, 1'b0, addr, 1'b0);
      end
      expectCycle(3'd2, !comp, 1'b0, addr, 1'b0);
      if (!comp) expectCycle(3'd3, 1'b1, 1'b0, addr, 1'b0);
      expectCycle(3'd4, 1'b1, 1'b1, addr, t == int'(cnt));
      prev = addr;
      addr = dir ? addr - 16'd1 : addr + 16'd1;
    end
    check("R8 addrEn low after final S4", addrEn, 1'b0);
    check(poke ? "R9 idle after ignored start" : "R5 idle after last transfer", phase, 3'd0);
    check("R7 S1 count", s1Seen, expS1);
    pokeOn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 phase", phase, 3'd0);
    check("R1 addrEn", addrEn, 1'b0);
    check("R1 strobes", {adStrobe, rdStrobe, wrStrobe, tc}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      runService(VEC[i][63:48], VEC[i][47:32], VEC[i][24], VEC[i][16],
                 int'(VEC[i][15:8]), VEC[i][0]);
    end

    // R1: reset taken in the middle of a service
    startAddr = 16'h2000; xferCount = 16'd10; countDown = 1'b0; compressed = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 phase after mid reset", phase, 3'd0);
    check("R1 addrEn after mid reset", addrEn, 1'b0);
    check("R1 strobes after mid reset", {adStrobe, rdStrobe, wrStrobe, tc}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    runService(16'h00FE, 16'd2, 1'b0, 1'b1, 2, 1'b0);

    summary();
  end

endmodule